// File: doc/BRIEF.md
# Three-Point Column Stencil Engine

This block sweeps an n-by-n grid of signed 16-bit samples held in an on-chip source memory and, for each grid cell, forms the weighted sum of its two vertical neighbours in the same column: k1 times the sample at the next row index plus k2 times the sample at the previous row index. The host fills the source memory through a write port while the engine is idle, then pulses start along with the two coefficients. The engine reads exactly one source word per clock, in linear address order (column index j outer, row index i inner, address j*n+i). A two-stage tap line supplies the older neighbour, so no second read port is needed.

The multiply-add is split into a product stage, a 33-bit sum stage and a saturate-and-write stage. One result is written per clock into a single-ported result memory. Cells on the first and last row of each column have a missing neighbour, and the engine writes zero there. When the final write has left the pipeline, a one-cycle done pulse is raised. The host then reads the results back through the same result-memory port.

Top module: `stencil_engine`

## Requirements
- R1: For every cell with 1 <= i <= n-2, the word at result address j*n+i equals sat(k1*b[j*n+i+1] + k2*b[j*n+i-1]). Here b is the source memory content and k1, k2 are the coefficients captured at start.
- R2: For every cell with i = 0 or i = n-1, the result word is zero.
- R3: The two products are added at 33-bit width and then clamped to the range -32768..32767, so an exact sum of +2^31 gives 32767 and a large negative sum gives -32768.
- R4: The coefficients are sampled only on the cycle a start is accepted. Changing k1_i or k2_i during a sweep does not affect that sweep's results.
- R5: A start pulse while busy_o is high is ignored. The running sweep is neither restarted nor extended, and it produces exactly one done pulse.
- R6: The done_o pulse is exactly one cycle wide. It first appears n*n+4 rising edges after the edge that accepts start. busy_o is high from the accepting edge until done_o rises, and low while done_o is high.
- R7: A source write request made while busy_o is high is discarded, and the memory keeps its previous content.
- R8: While idle, res_rdata_o presents the result word at res_addr_i one clock after the address is applied.
- R9: After reset, busy_o and done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted only while idle |
| k1_i | input | 16 | Signed coefficient for the next-row neighbour |
| k2_i | input | 16 | Signed coefficient for the previous-row neighbour |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle pulse after the final result write |
| src_we_i | input | 1 | Source memory write strobe, honoured only while idle |
| src_addr_i | input | $clog2(N*N) | Source write address j*n+i |
| src_wdata_i | input | 16 | Source write data, signed |
| res_addr_i | input | $clog2(N*N) | Result read address j*n+i |
| res_rdata_o | output | 16 | Result read data, one cycle after the address |

## Verification
A tap line that is misaligned by one stage, or that carries data across a column boundary, puts wrong values into interior cells next to each column edge. A readback after the very next sweep shows this. A sum register that is one bit too narrow flips the sign of saturated cells, and only the extreme-operand sweeps expose that. Faults in the sweep counter or in done sequencing show up within one sweep as a wrong done latency, an extra done pulse, or a misplaced result address.

// File: rtl/stencil_pkg.sv
package stencil_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned PROD_W = 2 * WORD_W;
  localparam int unsigned SUM_W  = PROD_W + 1;

  typedef logic signed [WORD_W-1:0] word_t;
  typedef logic signed [PROD_W-1:0] prod_t;
  typedef logic signed [SUM_W-1:0]  sum_t;

  function automatic word_t sat_word(sum_t v);
    if (&v[SUM_W-1:WORD_W-1] || ~|v[SUM_W-1:WORD_W-1]) return word_t'(v[WORD_W-1:0]);
    else if (v[SUM_W-1]) return word_t'({1'b1, {(WORD_W-1){1'b0}}});
    else return word_t'({1'b0, {(WORD_W-1){1'b1}}});
  endfunction
endpackage

// File: rtl/stencil_spram.sv
module stencil_spram #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem_q[addr_i] <= wdata_i;
      rdata_o <= mem_q[addr_i];
    end
  end
endmodule

// File: rtl/stencil_sweep.sv
module stencil_sweep #(
  parameter int unsigned N = 8,
  localparam int unsigned CELLS = N * N,
  localparam int unsigned SW = $clog2(CELLS + 1),
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  output logic          valid_o,
  output logic [SW-1:0] step_o,
  output logic [IW-1:0] icnt_o,
  output logic          last_o
);
  logic          run_q;
  logic [SW-1:0] step_q;
  logic [IW-1:0] icnt_q;

  // one extra step past the grid drains the final bottom-edge cell
  assign last_o  = run_q && (step_q == SW'(CELLS));
  assign valid_o = run_q;
  assign step_o  = step_q;
  assign icnt_o  = icnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      step_q <= '0;
      icnt_q <= '0;
    end else if (go_i) begin
      run_q  <= 1'b1;
      step_q <= '0;
      icnt_q <= '0;
    end else if (run_q) begin
      step_q <= step_q + SW'(1);
      icnt_q <= (icnt_q == IW'(N - 1)) ? '0 : icnt_q + IW'(1);
      if (last_o) run_q <= 1'b0;
    end
  end

  AST_SWEEP_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !go_i) |=> !run_q); // R6
endmodule

// File: rtl/stencil_taps.sv
module stencil_taps #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         col_start_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o
);
  logic [W-1:0] tap_q [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tap_q[k] <= '0;
      else if (shift_i) begin
        if (k == 0) tap_q[k] <= din_i;
        else        tap_q[k] <= col_start_i ? '0 : tap_q[k-1]; // flush at column entry
      end
    end
  end

  assign dout_o = tap_q[DEPTH-1];
endmodule

// File: rtl/stencil_mac.sv
module stencil_mac import stencil_pkg::*; #(
  parameter int unsigned AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic          in_zero_i,
  input  logic          in_last_i,
  input  logic [AW-1:0] in_addr_i,
  input  word_t         near_i,
  input  word_t         far_i,
  input  word_t         k1_i,
  input  word_t         k2_i,
  output logic          out_valid_o,
  output logic          out_last_o,
  output logic [AW-1:0] out_addr_o,
  output word_t         out_data_o
);
  prod_t         p1_q, p2_q;
  sum_t          sum_q;
  logic          v1_q, z1_q, l1_q, v2_q, z2_q, l2_q;
  logic [AW-1:0] a1_q, a2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p1_q <= '0; p2_q <= '0; sum_q <= '0;
      v1_q <= 1'b0; z1_q <= 1'b0; l1_q <= 1'b0; a1_q <= '0;
      v2_q <= 1'b0; z2_q <= 1'b0; l2_q <= 1'b0; a2_q <= '0;
    end else begin
      p1_q  <= prod_t'(k1_i) * prod_t'(near_i);
      p2_q  <= prod_t'(k2_i) * prod_t'(far_i);
      v1_q  <= in_valid_i; z1_q <= in_zero_i; l1_q <= in_last_i; a1_q <= in_addr_i;
      sum_q <= sum_t'(p1_q) + sum_t'(p2_q);
      v2_q  <= v1_q; z2_q <= z1_q; l2_q <= l1_q; a2_q <= a1_q;
    end
  end

  assign out_valid_o = v2_q;
  assign out_last_o  = l2_q;
  assign out_addr_o  = a2_q;
  assign out_data_o  = z2_q ? word_t'('0) : sat_word(sum_q);

  AST_MAC_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(in_valid_i, 2)); // R1
endmodule

// File: rtl/stencil_engine.sv
module stencil_engine import stencil_pkg::*; #(
  parameter int unsigned N = 8,
  localparam int unsigned AW = $clog2(N * N)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [WORD_W-1:0]   k1_i,
  input  logic [WORD_W-1:0]   k2_i,
  output logic                busy_o,
  output logic                done_o,
  input  logic                src_we_i,
  input  logic [AW-1:0]       src_addr_i,
  input  logic [WORD_W-1:0]   src_wdata_i,
  input  logic [AW-1:0]       res_addr_i,
  output logic [WORD_W-1:0]   res_rdata_o
);
  localparam int unsigned CELLS = N * N;
  localparam int unsigned SW    = $clog2(CELLS + 1);
  localparam int unsigned IW    = $clog2(N);

  logic  busy_q, done_q, accept;
  word_t k1_q, k2_q;

  assign accept = start_i && !busy_q;

  // sweep / stage A
  logic          sw_valid, sw_last;
  logic [SW-1:0] sw_step;
  logic [IW-1:0] sw_icnt;

  stencil_sweep #(.N(N)) u_sweep (
    .clk_i, .rst_ni, .go_i(accept),
    .valid_o(sw_valid), .step_o(sw_step), .icnt_o(sw_icnt), .last_o(sw_last)
  );

  // source memory: host port when idle, engine read port when busy
  logic          src_en, src_we;
  logic [AW-1:0] src_addr;
  logic [WORD_W-1:0] src_rdata;

  assign src_en   = busy_q ? (sw_valid && !sw_last) : src_we_i;
  assign src_we   = src_we_i && !busy_q;
  assign src_addr = busy_q ? sw_step[AW-1:0] : src_addr_i;

  stencil_spram #(.W(WORD_W), .DEPTH(CELLS)) u_src (
    .clk_i, .en_i(src_en), .we_i(src_we), .addr_i(src_addr),
    .wdata_i(src_wdata_i), .rdata_o(src_rdata)
  );

  // stage B: read data aligned with its step
  logic          vb_q, lb_q;
  logic [SW-1:0] step_b_q;
  logic [IW-1:0] icnt_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vb_q <= 1'b0; lb_q <= 1'b0; step_b_q <= '0; icnt_b_q <= '0;
    end else begin
      vb_q <= sw_valid; lb_q <= sw_last; step_b_q <= sw_step; icnt_b_q <= sw_icnt;
    end
  end

  logic [WORD_W-1:0] far_w;

  stencil_taps #(.W(WORD_W), .DEPTH(2)) u_taps (
    .clk_i, .rst_ni, .shift_i(vb_q), .col_start_i(icnt_b_q == '0),
    .din_i(src_rdata), .dout_o(far_w)
  );

  // word read at step s is the near neighbour of cell s-1
  logic          mac_v, mac_last;
  logic [AW-1:0] mac_addr;
  word_t         mac_data;

  stencil_mac #(.AW(AW)) u_mac (
    .clk_i, .rst_ni,
    .in_valid_i(vb_q && (step_b_q != '0)),
    .in_zero_i(icnt_b_q <= IW'(1)),
    .in_last_i(lb_q),
    .in_addr_i(AW'(step_b_q - SW'(1))),
    .near_i(word_t'(src_rdata)), .far_i(word_t'(far_w)),
    .k1_i(k1_q), .k2_i(k2_q),
    .out_valid_o(mac_v), .out_last_o(mac_last), .out_addr_o(mac_addr), .out_data_o(mac_data)
  );

  // result memory: single port, engine writes while busy
  logic          res_en, res_we;
  logic [AW-1:0] res_addr;

  assign res_we   = busy_q && mac_v;
  assign res_en   = busy_q ? mac_v : 1'b1;
  assign res_addr = busy_q ? mac_addr : res_addr_i;

  stencil_spram #(.W(WORD_W), .DEPTH(CELLS)) u_res (
    .clk_i, .en_i(res_en), .we_i(res_we), .addr_i(res_addr),
    .wdata_i(mac_data), .rdata_o(res_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; done_q <= 1'b0; k1_q <= '0; k2_q <= '0;
    end else begin
      done_q <= busy_q && mac_v && mac_last;
      if (accept) begin
        busy_q <= 1'b1;
        k1_q   <= word_t'(k1_i);
        k2_q   <= word_t'(k2_i);
      end else if (mac_v && mac_last) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R6
  AST_WRITE_IN_SWEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mac_v |-> busy_q); // R6
  AST_COEF_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(k1_q) && $stable(k2_q))); // R4
endmodule

// File: tb/sim_stencil_engine.sv
module sim_stencil_engine;
  localparam int N     = 8;
  localparam int CELLS = N * N;
  localparam int AW    = $clog2(CELLS);

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0, src_we_i = 1'b0;
  logic [15:0] k1_i = '0, k2_i = '0, src_wdata_i = '0;
  logic [AW-1:0] src_addr_i = '0, res_addr_i = '0;
  logic busy_o, done_o;
  logic [15:0] res_rdata_o;

  stencil_engine #(.N(N)) u0 (
    .clk_i(clk), .rst_ni, .start_i, .k1_i, .k2_i, .busy_o, .done_o,
    .src_we_i, .src_addr_i, .src_wdata_i, .res_addr_i, .res_rdata_o
  );

  always #5 clk = ~clk;

  int checks = 0, failures = 0, done_cnt = 0;
  logic signed [15:0] bm [CELLS];
  int    exp_q[$];
  string tag_q[$];
  logic  rd_req = 1'b0, rd_req_q = 1'b0;

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
    end
  endtask

  function automatic int expect_cell(int a, int k1, int k2);
    int i;
    longint s;
    i = a % N;
    if (i == 0 || i == N - 1) return 0;
    s = longint'(k1) * longint'(int'(bm[a+1])) + longint'(k2) * longint'(int'(bm[a-1]));
    if (s > 32767) return 32767;
    if (s < -32768) return -32768;
    return int'(s);
  endfunction

  // monitor: one cycle read latency (R8)
  always @(posedge clk) rd_req_q <= rd_req;
  always @(negedge clk) begin
    if (done_o) done_cnt++;
    if (rd_req_q && exp_q.size() > 0) begin
      int e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(int'($signed(res_rdata_o)) == e, {t, "/R8"}, int'($signed(res_rdata_o)), e);
    end
  end

  task automatic load_src();
    for (int a = 0; a < CELLS; a++) begin
      @(negedge clk);
      src_we_i = 1'b1; src_addr_i = AW'(a); src_wdata_i = bm[a];
    end
    @(negedge clk);
    src_we_i = 1'b0;
  endtask

  task automatic run_sweep(int k1, int k2, bit poke_start, bit poke_write);
    int cyc, d0;
    d0 = done_cnt;
    @(negedge clk);
    k1_i = 16'(k1); k2_i = 16'(k2); start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    cyc = 0;
    while (cyc < 1000) begin
      if (cyc > 0) @(negedge clk);
      if (cyc == 5) check(busy_o == 1'b1, "R6 busy during sweep", busy_o, 1);
      if (poke_start && cyc == 10) begin
        start_i = 1'b1; k1_i = 16'(k1 + 7); k2_i = 16'(k2 - 3);
      end
      if (cyc == 11) start_i = 1'b0;
      if (poke_write && cyc == 12) begin
        src_we_i = 1'b1; src_addr_i = AW'(10); src_wdata_i = 16'd1234;
      end
      if (cyc == 13) src_we_i = 1'b0;
      if (done_o) break;
      @(posedge clk);
      cyc++;
    end
    check(cyc == CELLS + 4, "R6 done latency", cyc, CELLS + 4);
    check(busy_o == 1'b0, "R6 idle at done", busy_o, 0);
    @(negedge clk);
    check(done_o == 1'b0, "R6 done width", done_o, 0);
    repeat (CELLS + 10) @(negedge clk);
    check(done_cnt == d0 + 1, "R5 single done", done_cnt - d0, 1);
  endtask

  task automatic read_all(int k1, int k2, string itag);
    for (int a = 0; a < CELLS; a++) begin
      @(negedge clk);
      res_addr_i = AW'(a);
      rd_req = 1'b1;
      exp_q.push_back(expect_cell(a, k1, k2));
      tag_q.push_back(((a % N) == 0 || (a % N) == N - 1) ? "R2" : itag);
    end
    @(negedge clk);
    rd_req = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(busy_o == 1'b0, "R9 busy after reset", busy_o, 0);
    check(done_o == 1'b0, "R9 done after reset", done_o, 0);

    for (int a = 0; a < CELLS; a++) bm[a] = 16'((a * 37 + 5) % 200 - 100);
    load_src();
    run_sweep(3, -5, 1'b0, 1'b0);
    read_all(3, -5, "R1");

    // distinct columns; start and coefficient change mid-sweep (R4, R5)
    for (int a = 0; a < CELLS; a++) bm[a] = 16'((a / N) * 1000 - (a % N) * 17 + (a % 3) * 5);
    load_src();
    run_sweep(-2, 7, 1'b1, 1'b0);
    read_all(-2, 7, "R4");

    // write while busy must be dropped; visible on the following sweep (R7)
    run_sweep(1, 1, 1'b0, 1'b1);
    run_sweep(1, 1, 1'b0, 1'b0);
    read_all(1, 1, "R7");

    // saturation corners (R3)
    for (int a = 0; a < CELLS; a++) bm[a] = 16'sd32767;
    load_src();
    run_sweep(32767, 32767, 1'b0, 1'b0);
    read_all(32767, 32767, "R3");
    run_sweep(-32768, -32768, 1'b0, 1'b0);
    read_all(-32768, -32768, "R3");
    for (int a = 0; a < CELLS; a++) bm[a] = -16'sd32768;
    load_src();
    run_sweep(-32768, -32768, 1'b0, 1'b0);
    read_all(-32768, -32768, "R3");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule